// File: doc/BRIEF.md
# Zero-Suppressed Conversion Sequencer

This block drives an analog-to-digital converter through one event's worth of channel readout. For each event it takes a 32-bit hit bitmap. Each set bit stands for a channel whose signal crossed threshold. The block then visits only those channels. It issues a one-cycle start strobe with the channel address for each one and holds that address for a programmable number of clock cycles.

Channels without a hit are skipped entirely. The series ends as soon as the highest flagged channel has been held, so readout time grows with the number of hits rather than with the channel count. A one-cycle done pulse and a count of converted channels close each series. The block takes a new bitmap only while it is idle, and it signals this on a ready output.

Top module: `zs_conv_sequencer`

## Requirements
- R1: After reset, and whenever the block is idle, `map_ready` is 1 while `conv_start` and `seq_done` are 0. Reset also clears `conv_count` to 0.
- R2: A bitmap is taken only at a clock edge where `map_valid` and `map_ready` are both 1. A `map_valid` during a series has no effect on that series' strobes, addresses, done timing or count, and starts no second series.
- R3: Bit i of `map_bits` flags channel i. Exactly one strobe is issued per flagged channel, in ascending index order, and `conv_chan` carries the binary channel index in the strobe cycle.
- R4: With hold value H taken from `hold_cycles` at acceptance (0 treated as 1), the first strobe comes in the cycle right after the accepting edge and later strobes follow exactly H cycles apart.
- R5: Between strobes of a series, `conv_chan` stays at the address of the most recent strobe.
- R6: `seq_done` is a one-cycle pulse that comes H cycles after the last strobe. `map_ready` returns in the following cycle, and no strobe follows the last flagged channel.
- R7: An all-zero bitmap gives `seq_done` in the cycle right after acceptance, with no strobe and a count of 0.
- R8: During the done pulse, `conv_count` equals the number of flagged channels. It holds that value until the next bitmap is accepted.
- R9: Changes on `hold_cycles` after acceptance do not change the strobe spacing or the done timing of the running series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| map_valid | input | 1 | Hit bitmap offered |
| map_bits | input | 32 | Hit bitmap, bit i flags channel i |
| hold_cycles | input | 8 | Clock cycles each conversion is held (0 acts as 1) |
| map_ready | output | 1 | Idle, bitmap can be accepted |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_chan | output | 5 | Channel address for the converter |
| seq_done | output | 1 | One-cycle end-of-series pulse |
| conv_count | output | 6 | Number of channels converted in the last series |

## Verification
Counting cycle c as the cycle after the c-th edge from the accepting edge, the k-th strobe (from 0) is due in cycle 1+k·H. With N hits, the done pulse is due in cycle N·H+1, and ready and the held count are due in cycle N·H+2. Each scenario task computes these cycle numbers from the bitmap and hold value alone. It samples every output one time unit after each rising edge and drives inputs on falling edges, so each comparison sees the settled value for exactly one cycle. Intrusive `map_valid` pulses and `hold_cycles` changes are applied only on edges where the series is still running, so their lack of effect shows in the same per-cycle comparison.

// File: rtl/zsq_pkg.sv
package zsq_pkg;

    localparam int unsigned DEF_N_CH   = 32;
    localparam int unsigned DEF_HOLD_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    // Effective hold minus one: a zero request behaves like one cycle.
    function automatic logic [DEF_HOLD_W-1:0] hold_minus_one(input logic [DEF_HOLD_W-1:0] h);
        return (h == '0) ? '0 : h - 1'b1;
    endfunction

endpackage

// File: rtl/zsq_pick_lowest.sv
module zsq_pick_lowest #(
    parameter int unsigned N  = 32,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  rest
);
    logic [N-1:0] below;
    logic [N-1:0] first;

    for (genvar i = 0; i < N; i++) begin : g_chain
        if (i == 0) begin : g_base
            assign below[i] = 1'b0;
        end else begin : g_link
            assign below[i] = below[i-1] | bits[i-1];
        end
        assign first[i] = bits[i] & ~below[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end

    assign found = |bits;
    assign rest  = bits & ~first;

endmodule

// File: rtl/zsq_hold_timer.sv
module zsq_hold_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

    // R4: the hold counter never wraps below zero
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !load) |=> (cnt == '0));

endmodule

// File: rtl/zs_conv_sequencer.sv
module zs_conv_sequencer
    import zsq_pkg::*;
#(
    parameter int unsigned N_CH   = DEF_N_CH,
    parameter int unsigned HOLD_W = DEF_HOLD_W,
    localparam int unsigned CH_W  = $clog2(N_CH),
    localparam int unsigned CNT_W = $clog2(N_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              map_valid,
    input  logic [N_CH-1:0]   map_bits,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              map_ready,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    output logic              seq_done,
    output logic [CNT_W-1:0]  conv_count
);
    seq_state_t        state;
    logic [N_CH-1:0]   remain;
    logic [HOLD_W-1:0] hold_q;
    logic [CH_W-1:0]   chan_q;
    logic              strobe_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              accept;
    logic [N_CH-1:0]   pick_src;
    logic              pick_found;
    logic [CH_W-1:0]   pick_idx;
    logic [N_CH-1:0]   pick_rest;
    logic [HOLD_W-1:0] hold_new;
    logic              tmr_last;
    logic              tmr_load;
    logic [HOLD_W-1:0] tmr_val;
    logic              advance;

    assign accept   = (state == ST_IDLE) && map_valid;
    assign pick_src = (state == ST_IDLE) ? map_bits : remain;
    assign hold_new = (hold_cycles == '0) ? '0 : hold_cycles - 1'b1;
    assign advance  = (state == ST_CONV) && tmr_last && pick_found;
    assign tmr_load = (accept && pick_found) || advance;
    assign tmr_val  = accept ? hold_new : hold_q;

    zsq_pick_lowest #(.N(N_CH), .IW(CH_W)) u_pick (
        .bits  (pick_src),
        .found (pick_found),
        .idx   (pick_idx),
        .rest  (pick_rest)
    );

    zsq_hold_timer #(.W(HOLD_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            remain   <= '0;
            hold_q   <= '0;
            chan_q   <= '0;
            strobe_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            strobe_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (map_valid) begin
                        hold_q <= hold_new;
                        remain <= pick_rest;
                        if (pick_found) begin
                            chan_q   <= pick_idx;
                            strobe_q <= 1'b1;
                            cnt_q    <= CNT_W'(1);
                            state    <= ST_CONV;
                        end else begin
                            cnt_q <= '0;
                            state <= ST_DONE;
                        end
                    end
                end
                ST_CONV: begin
                    if (tmr_last) begin
                        if (pick_found) begin
                            chan_q   <= pick_idx;
                            remain   <= pick_rest;
                            strobe_q <= 1'b1;
                            cnt_q    <= cnt_q + 1'b1;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign map_ready  = (state == ST_IDLE);
    assign seq_done   = (state == ST_DONE);
    assign conv_start = strobe_q;
    assign conv_chan  = chan_q;
    assign conv_count = cnt_q;

    // R1: an idle block neither strobes nor reports done
    p_ready_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        map_ready |-> (!conv_start && !seq_done));

    // R2: a running series is not cut short by new offers
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!map_ready && !seq_done) |=> !map_ready);

    // R3: strobes inside a series move to strictly higher channels
    p_ascend_r3: assert property (@(posedge clk) disable iff (rst)
        (conv_start && !$past(map_ready)) |-> (conv_chan > $past(conv_chan)));

    // R5: address steady between strobes
    p_chan_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!map_ready && !conv_start && !seq_done) |-> $stable(conv_chan));

    // R6: done lasts one cycle and is followed by idle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> (map_ready && !seq_done && !conv_start));

    // R7: empty bitmap finishes at once without conversion
    p_empty_done_r7: assert property (@(posedge clk) disable iff (rst)
        (map_valid && map_ready && map_bits == '0) |=> (seq_done && !conv_start));

    // R8: count is held while idle without a new bitmap
    p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (map_ready && !map_valid) |=> $stable(conv_count));

endmodule

// File: tb/zs_conv_sequencer_test.sv
module zs_conv_sequencer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        map_valid = 1'b0;
    logic [31:0] map_bits = '0;
    logic [7:0]  hold_cycles = 8'd1;
    logic        map_ready;
    logic        conv_start;
    logic [4:0]  conv_chan;
    logic        seq_done;
    logic [5:0]  conv_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    zs_conv_sequencer uut (
        .clk         (clk),
        .rst         (rst),
        .map_valid   (map_valid),
        .map_bits    (map_bits),
        .hold_cycles (hold_cycles),
        .map_ready   (map_ready),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .seq_done    (seq_done),
        .conv_count  (conv_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        check(map_ready === 1'b1, "R1", "ready after reset", int'(map_ready), 1);
        check(conv_start === 1'b0 && seq_done === 1'b0, "R1", "start/done after reset",
              int'({conv_start, seq_done}), 0);
        check(conv_count === 6'd0, "R1", "count after reset", int'(conv_count), 0);
    endtask

    // One series: intrude offers new bitmaps while busy (R2),
    // hold_swap changes hold_cycles mid-series (R9).
    task automatic run_series(input logic [31:0] bits, input int hold,
                              input bit intrude, input bit hold_swap, input string tag);
        int exp_ch[32];
        int n = 0;
        int h;
        int total;
        int bad_chan = 0, bad_space = 0, bad_done = 0, bad_stable = 0, strobes = 0;
        for (int i = 0; i < 32; i++) begin
            if (bits[i]) begin
                exp_ch[n] = i;
                n++;
            end
        end
        h = (hold == 0) ? 1 : hold;
        total = n * h + 1;

        @(negedge clk);
        check(map_ready === 1'b1, "R1", {tag, " ready before offer"}, int'(map_ready), 1);
        map_valid   = 1'b1;
        map_bits    = bits;
        hold_cycles = 8'(hold);
        @(posedge clk); #1;
        for (int c = 1; c <= total; c++) begin
            bit exp_str;
            int k;
            if (c > 1) begin
                @(posedge clk); #1;
            end
            exp_str = (n > 0) && (c <= n * h) && (((c - 1) % h) == 0);
            k = (c - 1) / h;
            if (conv_start !== exp_str) bad_space++;
            if (conv_start === 1'b1) strobes++;
            if (exp_str && conv_chan !== 5'(exp_ch[k])) bad_chan++;
            if (!exp_str && c <= n * h && conv_chan !== 5'(exp_ch[k])) bad_stable++;
            if (seq_done !== (c == total)) bad_done++;
            if (c == total)
                check(conv_count === 6'(n), "R8", {tag, " count at done"}, int'(conv_count), n);
            @(negedge clk);
            map_valid = intrude && (c < 3) && (c < n * h);
            map_bits  = ~bits;
            if (hold_swap) hold_cycles = 8'(hold + 7);
        end
        map_valid = 1'b0;
        check(strobes == n, "R3", {tag, " strobe count"}, strobes, n);
        check(bad_chan == 0, "R3", {tag, " ascending channel order"}, bad_chan, 0);
        check(bad_space == 0, "R4", {tag, " strobe cycles"}, bad_space, 0);
        check(bad_stable == 0, "R5", {tag, " address held"}, bad_stable, 0);
        check(bad_done == 0, "R6", {tag, " done cycle"}, bad_done, 0);
        if (n == 0)
            check(bad_done == 0 && strobes == 0, "R7", {tag, " empty bitmap"}, strobes, 0);
        if (intrude)
            check(bad_space == 0 && bad_chan == 0 && bad_done == 0, "R2",
                  {tag, " busy offer ignored"}, bad_space + bad_chan + bad_done, 0);
        if (hold_swap)
            check(bad_space == 0 && bad_done == 0, "R9", {tag, " hold latched"},
                  bad_space + bad_done, 0);
        @(posedge clk); #1;
        check(map_ready === 1'b1 && conv_start === 1'b0, "R6", {tag, " idle after done"},
              int'({map_ready, conv_start}), 2);
        check(conv_count === 6'(n), "R8", {tag, " count held"}, int'(conv_count), n);
        hold_cycles = 8'd1;
    endtask

    initial begin
        check_reset();
        run_series(32'h8001_8002, 3, 1'b0, 1'b0, "four hits");
        run_series(32'h8000_8002, 5, 1'b0, 1'b0, "three hits");
        run_series(32'h0000_0000, 4, 1'b0, 1'b0, "empty");
        run_series(32'hFFFF_FFFF, 1, 1'b0, 1'b0, "all hits");
        run_series(32'h0000_0001, 0, 1'b0, 1'b0, "chan0 hold0");
        run_series(32'h8000_0000, 2, 1'b0, 1'b0, "chan31");
        run_series(32'h0F00_0010, 2, 1'b1, 1'b0, "busy offer");
        run_series(32'h4000_0204, 3, 1'b0, 1'b1, "hold change");
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule